// File: doc/BRIEF.md
# Dual-Mode IQ Sample Bus Receiver

This block sits at the input of one quadrature upconversion channel. It takes complex baseband samples from an external source and turns them into I/Q pairs for the datapath. The source can use one of two bus layouts. In the wide layout, one 32-bit word arrives per strobe. The upper half holds I, the lower half holds Q, and each half has its own parity bit. In the narrow layout, a 16-bit lane runs at double data rate. The word sent during the high phase of the forwarded clock is I, and the word sent during the low phase is Q. One parity line serves both words: it carries the high-phase word's parity during the high phase and the low-phase word's parity during the low phase.

The block runs on an internal clock at twice the forwarded clock rate. A phase input tells it which half of the forwarded clock each strobed word belongs to. Each half-word is checked against a configurable parity sense. Errors are reported in three ways: per sample, in sticky per-half flags, and in a saturating count of failing half-words. The bus layout is latched only while reset is held, so a pair can never mix halves captured under two different layouts.

Top module: `iq_lane_rx`

## Requirements
- R1: In wide mode (mode latched as 0), each cycle with `bus_strobe` high yields `pair_valid` high in the next cycle. `pair_i` is `bus_data[31:16]` and `pair_q` is `bus_data[15:0]`. `bus_phase_hi` has no effect. Without a strobe, `pair_valid` is low.
- R2: In wide mode, `bus_par[1]` is the parity bit for bits 31:16 and drives `pair_err_i`. `bus_par[0]` is the parity bit for bits 15:0 and drives `pair_err_q`.
- R3: In DDR mode (mode latched as 1), a strobed word with `bus_phase_hi`=1 is taken from `bus_data[15:0]` as I. A later strobed word with `bus_phase_hi`=0 is taken as Q. The pair appears with `pair_valid` high in the cycle after the Q word. The I word alone never produces a pair.
- R4: In DDR mode, `bus_par[0]` is sampled with each word and covers that word. `bus_data[31:16]` and `bus_par[1]` have no effect.
- R5: `cfg_odd`=0 selects even parity, and a half fails when the count of ones in its 16 bits plus its parity bit is odd. `cfg_odd`=1 selects odd parity, and a half fails when that count is even. The input takes effect on the word in the same cycle.
- R6: In DDR mode, a Q word with no pending I word is dropped and yields no pair. A second I word before any Q replaces the pending one.
- R7: `sticky_err_i` and `sticky_err_q` are set one cycle after a valid pair carrying that half's error. They stay set until `clr_err` is high at a clock edge. A new error in the same cycle as a clear leaves the flag set.
- R8: `err_count` adds the number of failing halves of each valid pair (0, 1 or 2) one cycle after the pair. It saturates at all ones. `clr_err` restarts it from zero, and errors of the same cycle are still added.
- R9: `cfg_ddr` is latched only while `rst_n` is low. A change of `cfg_ddr` while running has no effect until the next reset.
- R10: While `rst_n` is low at a clock edge, `pair_valid`, both sticky flags and `err_count` become 0 and any pending I word is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, twice the forwarded clock rate |
| rst_n | input | 1 | Synchronous reset, active low; the bus layout is latched while low |
| cfg_ddr | input | 1 | Bus layout: 0 wide single-edge, 1 narrow DDR |
| cfg_odd | input | 1 | Parity sense: 0 even, 1 odd |
| clr_err | input | 1 | Clears sticky flags and error count |
| bus_strobe | input | 1 | A word is present on the bus this cycle |
| bus_phase_hi | input | 1 | DDR only: 1 for the high-phase (I) word, 0 for the low-phase (Q) word |
| bus_data | input | 2*HALF_W | Bus data; the lower half is the DDR lane |
| bus_par | input | 2 | Parity bits; bit 0 is the DDR parity line |
| pair_valid | output | 1 | A rebuilt I/Q pair is presented |
| pair_i | output | HALF_W | I sample |
| pair_q | output | HALF_W | Q sample |
| pair_err_i | output | 1 | Parity failure on the I half of this pair |
| pair_err_q | output | 1 | Parity failure on the Q half of this pair |
| sticky_err_i | output | 1 | Sticky I-half error flag |
| sticky_err_q | output | 1 | Sticky Q-half error flag |
| err_count | output | CNT_W | Saturating count of failing half-words |

## Verification
The bench keeps HALF_W at 16 so the wide and DDR layouts match the real 32-bit bus. It reduces CNT_W to 4, so a short burst of double-error words drives the counter to its saturation value of 15 and back through clears. Injected parity faults, clears at random cycles, and DDR orphan and repeated-I sequences are all checked against a behavioural reference on every clock. A mode flip during a run confirms that the latched layout holds until the next reset.

// File: rtl/iq_rx_pkg.sv
package iq_rx_pkg;

  typedef enum logic {
    BUS_WIDE = 1'b0,
    BUS_DDR  = 1'b1
  } bus_mode_e;

  localparam int unsigned PAR_MAX_W = 64;

  // A half fails when the ones count of data plus parity differs from the
  // selected sense (0: even total expected, 1: odd total expected).
  function automatic logic half_par_fail(input logic [PAR_MAX_W-1:0] data,
                                         input logic par_bit,
                                         input logic odd_sense);
    return (^data) ^ par_bit ^ odd_sense;
  endfunction

endpackage

// File: rtl/iq_half_check.sv
module iq_half_check
  import iq_rx_pkg::*;
#(
  parameter int unsigned HALF_W = 16
) (
  input  logic [HALF_W-1:0] data,
  input  logic              par_bit,
  input  logic              odd_sense,
  output logic              fail
);

  logic [PAR_MAX_W-1:0] data_ext;

  always_comb begin
    data_ext = '0;
    data_ext[HALF_W-1:0] = data;
    fail = half_par_fail(data_ext, par_bit, odd_sense);
  end

endmodule

// File: rtl/iq_pair_builder.sv
module iq_pair_builder
  import iq_rx_pkg::*;
#(
  parameter int unsigned HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_mode_e         mode,
  input  logic              strobe,
  input  logic              phase_hi,
  input  logic [HALF_W-1:0] lane_hi,
  input  logic [HALF_W-1:0] lane_lo,
  input  logic              fail_i,
  input  logic              fail_q,
  output logic              pair_done,
  output logic              hold_load,
  output logic              orphan_drop,
  output logic              out_valid,
  output logic [HALF_W-1:0] out_i,
  output logic [HALF_W-1:0] out_q,
  output logic              out_err_i,
  output logic              out_err_q
);

  logic              hold_v;
  logic [HALF_W-1:0] hold_i;
  logic              hold_err;
  logic              is_wide;
  logic              ddr_fall;

  assign is_wide     = (mode == BUS_WIDE);
  assign ddr_fall    = strobe && !is_wide && !phase_hi;
  assign hold_load   = strobe && !is_wide && phase_hi;
  assign pair_done   = (strobe && is_wide) || (ddr_fall && hold_v);
  assign orphan_drop = ddr_fall && !hold_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v    <= 1'b0;
      hold_i    <= '0;
      hold_err  <= 1'b0;
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
      out_err_i <= 1'b0;
      out_err_q <= 1'b0;
    end else begin
      out_valid <= pair_done;
      if (pair_done) begin
        out_i     <= is_wide ? lane_hi : hold_i;
        out_err_i <= is_wide ? fail_i  : hold_err;
        out_q     <= lane_lo;
        out_err_q <= fail_q;
      end
      if (hold_load) begin
        hold_v   <= 1'b1;
        hold_i   <= lane_lo;
        hold_err <= fail_i;
      end else if (pair_done) begin
        hold_v <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/iq_err_tally.sv
module iq_err_tally #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ev_valid,
  input  logic             ev_err_i,
  input  logic             ev_err_q,
  output logic             sticky_i,
  output logic             sticky_q,
  output logic [CNT_W-1:0] count
);

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] base,
                                               input logic [1:0] inc);
    logic [CNT_W:0] sum;
    sum = {1'b0, base} + {{(CNT_W-1){1'b0}}, inc};
    return sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
  endfunction

  logic [1:0]       step;
  logic [CNT_W-1:0] base;

  always_comb begin
    step = ev_valid ? ({1'b0, ev_err_i} + {1'b0, ev_err_q}) : 2'd0;
    base = clr ? '0 : count;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sticky_i <= 1'b0;
      sticky_q <= 1'b0;
      count    <= '0;
    end else begin
      sticky_i <= (sticky_i && !clr) || (ev_valid && ev_err_i);
      sticky_q <= (sticky_q && !clr) || (ev_valid && ev_err_q);
      count    <= sat_add(base, step);
    end
  end

endmodule

// File: rtl/iq_lane_rx.sv
module iq_lane_rx
  import iq_rx_pkg::*;
#(
  parameter int unsigned HALF_W = 16,
  parameter int unsigned CNT_W  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_ddr,
  input  logic                  cfg_odd,
  input  logic                  clr_err,
  input  logic                  bus_strobe,
  input  logic                  bus_phase_hi,
  input  logic [2*HALF_W-1:0]   bus_data,
  input  logic [1:0]            bus_par,
  output logic                  pair_valid,
  output logic [HALF_W-1:0]     pair_i,
  output logic [HALF_W-1:0]     pair_q,
  output logic                  pair_err_i,
  output logic                  pair_err_q,
  output logic                  sticky_err_i,
  output logic                  sticky_err_q,
  output logic [CNT_W-1:0]      err_count
);

  localparam int unsigned WORD_W = 2 * HALF_W;
  localparam int unsigned N_HALF = 2;
  localparam int unsigned IDX_I  = 1;
  localparam int unsigned IDX_Q  = 0;

  bus_mode_e         mode_q;
  logic [HALF_W-1:0] lane_hi;
  logic [HALF_W-1:0] lane_lo;
  logic [HALF_W-1:0] chk_data [N_HALF];
  logic              chk_par  [N_HALF];
  logic              chk_fail [N_HALF];
  logic              pair_done;
  logic              hold_load;
  logic              orphan_drop;

  assign lane_hi = bus_data[WORD_W-1:HALF_W];
  assign lane_lo = bus_data[HALF_W-1:0];

  // Layout is captured only while held in reset.
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= bus_mode_e'(cfg_ddr);
  end

  for (genvar h = 0; h < N_HALF; h++) begin : g_half
    if (h == IDX_I) begin : g_i
      // Wide: upper half with its own bit. DDR: lane word with the shared line.
      assign chk_data[h] = (mode_q == BUS_DDR) ? lane_lo    : lane_hi;
      assign chk_par[h]  = (mode_q == BUS_DDR) ? bus_par[0] : bus_par[1];
    end else begin : g_q
      assign chk_data[h] = lane_lo;
      assign chk_par[h]  = bus_par[0];
    end
    iq_half_check #(.HALF_W(HALF_W)) u_chk (
      .data      (chk_data[h]),
      .par_bit   (chk_par[h]),
      .odd_sense (cfg_odd),
      .fail      (chk_fail[h])
    );
  end

  iq_pair_builder #(.HALF_W(HALF_W)) u_pair (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode_q),
    .strobe      (bus_strobe),
    .phase_hi    (bus_phase_hi),
    .lane_hi     (lane_hi),
    .lane_lo     (lane_lo),
    .fail_i      (chk_fail[IDX_I]),
    .fail_q      (chk_fail[IDX_Q]),
    .pair_done   (pair_done),
    .hold_load   (hold_load),
    .orphan_drop (orphan_drop),
    .out_valid   (pair_valid),
    .out_i       (pair_i),
    .out_q       (pair_q),
    .out_err_i   (pair_err_i),
    .out_err_q   (pair_err_q)
  );

  iq_err_tally #(.CNT_W(CNT_W)) u_tally (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr_err),
    .ev_valid (pair_valid),
    .ev_err_i (pair_err_i),
    .ev_err_q (pair_err_q),
    .sticky_i (sticky_err_i),
    .sticky_q (sticky_err_q),
    .count    (err_count)
  );

endmodule

// File: rtl/iq_lane_rx_chk.sv
module iq_lane_rx_chk
  import iq_rx_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_err,
  input logic             bus_strobe,
  input logic             bus_phase_hi,
  input bus_mode_e        mode_q,
  input logic             pair_done,
  input logic             hold_load,
  input logic             orphan_drop,
  input logic             pair_valid,
  input logic             pair_err_i,
  input logic             pair_err_q,
  input logic             sticky_err_i,
  input logic             sticky_err_q,
  input logic [CNT_W-1:0] err_count
);

  logic was_run = 1'b0;
  always_ff @(posedge clk) was_run <= rst_n;

  p_wide_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe && mode_q == BUS_WIDE) |=> pair_valid);

  p_ddr_fall_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_valid && mode_q == BUS_DDR) |-> $past(bus_strobe && !bus_phase_hi));

  p_rise_no_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hold_load |=> !pair_valid);

  p_pair_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pair_done |-> bus_strobe);

  p_orphan_r6: assert property (@(posedge clk) disable iff (!rst_n)
    orphan_drop |=> !pair_valid);

  p_ddr_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_valid && mode_q == BUS_DDR) |=> !pair_valid);

  p_sticky_set_i_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_valid && pair_err_i) |=> sticky_err_i);

  p_sticky_set_q_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_valid && pair_err_q) |=> sticky_err_q);

  p_sticky_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((sticky_err_i || sticky_err_q) && !clr_err) |=>
      (sticky_err_i || sticky_err_q));

  p_count_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_err |=> err_count >= $past(err_count));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_err && !pair_valid) |=> (err_count == '0 && !sticky_err_i && !sticky_err_q));

  p_mode_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    was_run |-> $stable(mode_q));

endmodule

bind iq_lane_rx iq_lane_rx_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .clr_err      (clr_err),
  .bus_strobe   (bus_strobe),
  .bus_phase_hi (bus_phase_hi),
  .mode_q       (mode_q),
  .pair_done    (pair_done),
  .hold_load    (hold_load),
  .orphan_drop  (orphan_drop),
  .pair_valid   (pair_valid),
  .pair_err_i   (pair_err_i),
  .pair_err_q   (pair_err_q),
  .sticky_err_i (sticky_err_i),
  .sticky_err_q (sticky_err_q),
  .err_count    (err_count)
);

// File: tb/sim_iq_lane_rx.sv
`timescale 1ns/1ps
module sim_iq_lane_rx;

  localparam int HW   = 16;
  localparam int CW   = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_ddr = 1'b0;
  logic          cfg_odd = 1'b0;
  logic          clr_err = 1'b0;
  logic          bus_strobe = 1'b0;
  logic          bus_phase_hi = 1'b0;
  logic [31:0]   bus_data = '0;
  logic [1:0]    bus_par = '0;
  logic          pair_valid;
  logic [HW-1:0] pair_i;
  logic [HW-1:0] pair_q;
  logic          pair_err_i;
  logic          pair_err_q;
  logic          sticky_err_i;
  logic          sticky_err_q;
  logic [CW-1:0] err_count;

  always #2.5 clk = ~clk;

  iq_lane_rx #(.HALF_W(HW), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_ddr(cfg_ddr), .cfg_odd(cfg_odd),
    .clr_err(clr_err), .bus_strobe(bus_strobe), .bus_phase_hi(bus_phase_hi),
    .bus_data(bus_data), .bus_par(bus_par), .pair_valid(pair_valid),
    .pair_i(pair_i), .pair_q(pair_q), .pair_err_i(pair_err_i),
    .pair_err_q(pair_err_q), .sticky_err_i(sticky_err_i),
    .sticky_err_q(sticky_err_q), .err_count(err_count)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  function automatic bit ref_fail(input logic [15:0] d, input logic p, input logic odd);
    int ones = 0;
    for (int k = 0; k < 16; k++) ones += int'(d[k]);
    ones += int'(p);
    return (ones % 2) != int'(odd);
  endfunction

  bit          m_started = 0;
  bit          m_rst = 1;
  bit          m_mode = 0;
  logic [15:0] pend_i[$];
  bit          pend_e[$];
  bit          e_valid = 0;
  logic [15:0] e_i = '0;
  logic [15:0] e_q = '0;
  bit          e_ei = 0;
  bit          e_eq = 0;
  bit          e_si = 0;
  bit          e_sq = 0;
  int          e_cnt = 0;
  string       e_dtag = "R1";
  string       e_etag = "R2";

  always @(posedge clk) begin
    m_started = 1;
    m_rst = !rst_n;
    if (!rst_n) begin
      m_mode = cfg_ddr;
      pend_i = {};
      pend_e = {};
      e_valid = 0; e_ei = 0; e_eq = 0;
      e_si = 0; e_sq = 0; e_cnt = 0;
    end else begin
      if (clr_err) begin e_si = 0; e_sq = 0; e_cnt = 0; end
      if (e_valid) begin
        if (e_ei) e_si = 1;
        if (e_eq) e_sq = 1;
        e_cnt += int'(e_ei) + int'(e_eq);
        if (e_cnt > CMAX) e_cnt = CMAX;
      end
      e_valid = 0;
      e_dtag = m_mode ? "R3" : "R1";
      e_etag = cfg_odd ? "R5" : (m_mode ? "R4" : "R2");
      if (bus_strobe) begin
        if (!m_mode) begin
          e_valid = 1;
          e_i = bus_data[31:16];
          e_q = bus_data[15:0];
          e_ei = ref_fail(bus_data[31:16], bus_par[1], cfg_odd);
          e_eq = ref_fail(bus_data[15:0], bus_par[0], cfg_odd);
        end else if (bus_phase_hi) begin
          pend_i = {};
          pend_e = {};
          pend_i.push_back(bus_data[15:0]);
          pend_e.push_back(ref_fail(bus_data[15:0], bus_par[0], cfg_odd));
        end else if (pend_i.size() > 0) begin
          e_valid = 1;
          e_i = pend_i.pop_front();
          e_ei = pend_e.pop_front();
          e_q = bus_data[15:0];
          e_eq = ref_fail(bus_data[15:0], bus_par[0], cfg_odd);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (m_started && !done) begin
      check(pair_valid === e_valid, m_rst ? "R10" : e_dtag, "pair_valid",
            int'(pair_valid), int'(e_valid));
      if (e_valid) begin
        check(pair_i === e_i, e_dtag, "pair_i", int'(pair_i), int'(e_i));
        check(pair_q === e_q, e_dtag, "pair_q", int'(pair_q), int'(e_q));
        check(pair_err_i === e_ei, e_etag, "pair_err_i", int'(pair_err_i), int'(e_ei));
        check(pair_err_q === e_eq, e_etag, "pair_err_q", int'(pair_err_q), int'(e_eq));
      end
      check(sticky_err_i === e_si, m_rst ? "R10" : "R7", "sticky_err_i",
            int'(sticky_err_i), int'(e_si));
      check(sticky_err_q === e_sq, m_rst ? "R10" : "R7", "sticky_err_q",
            int'(sticky_err_q), int'(e_sq));
      check(int'(err_count) == e_cnt, m_rst ? "R10" : "R8", "err_count",
            int'(err_count), e_cnt);
    end
  end

  // ---------------- stimulus ----------------
  task automatic drive_raw(input bit s, input bit ph, input logic [31:0] d,
                           input logic [1:0] p, input bit clr);
    @(negedge clk);
    bus_strobe = s; bus_phase_hi = ph; bus_data = d; bus_par = p; clr_err = clr;
  endtask

  task automatic drive(input bit s, input bit ph, input logic [31:0] d,
                       input bit bad_hi, input bit bad_lo, input bit clr);
    logic [1:0] p;
    p[1] = (^d[31:16]) ^ cfg_odd ^ bad_hi;
    p[0] = (^d[15:0]) ^ cfg_odd ^ bad_lo;
    drive_raw(s, ph, d, p, clr);
  endtask

  task automatic settle();
    @(negedge clk);
    bus_strobe = 0; clr_err = 0;
  endtask

  task automatic rand_run(input int n, input int bad_rate);
    for (int k = 0; k < n; k++)
      drive($urandom % 4 != 0, 1'($urandom), $urandom,
            ($urandom % bad_rate) == 0, ($urandom % bad_rate) == 0,
            ($urandom % 12) == 0);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(pair_valid == 0 && err_count == 0 && !sticky_err_i && !sticky_err_q,
          "R10", "reset state", int'(err_count), 0);
    rst_n = 1;

    // Wide mode, even parity
    rand_run(60, 5);
    drive(1, 1, 32'hA5C3_0F1E, 0, 0, 0);
    settle();
    check(pair_valid && pair_i == 16'hA5C3 && pair_q == 16'h0F1E, "R1",
          "wide split", int'(pair_i), 16'hA5C3);
    drive(1, 0, 32'h1357_2468, 1, 0, 0);
    settle();
    check(pair_err_i == 1 && pair_err_q == 0, "R2", "upper-only fault",
          int'({pair_err_i, pair_err_q}), 2);
    settle();
    check(!pair_valid, "R1", "no strobe no pair", int'(pair_valid), 0);

    // Parity sense
    cfg_odd = 1;
    drive_raw(1, 0, 32'h0003_0001, 2'b10, 0);
    settle();
    check(!pair_err_i && !pair_err_q, "R5", "odd sense pass",
          int'({pair_err_i, pair_err_q}), 0);
    cfg_odd = 0;
    drive_raw(1, 0, 32'h0003_0001, 2'b10, 0);
    settle();
    check(pair_err_i && pair_err_q, "R5", "even sense fail",
          int'({pair_err_i, pair_err_q}), 3);
    cfg_odd = 1;
    rand_run(40, 4);

    // Saturation and clears
    drive(0, 0, 0, 0, 0, 1);
    for (int k = 0; k < 12; k++) drive(1, 0, $urandom, 1, 1, 0);
    settle();
    settle();
    check(int'(err_count) == CMAX, "R8", "saturation", int'(err_count), CMAX);
    drive(0, 0, 0, 0, 0, 1);
    settle();
    check(err_count == 0 && !sticky_err_i, "R8", "clear", int'(err_count), 0);

    // Mode flip while running is ignored
    cfg_ddr = 1;
    drive(1, 0, 32'hBEEF_1234, 0, 0, 0);
    settle();
    check(pair_valid && pair_i == 16'hBEEF, "R9", "layout kept", int'(pair_i), 16'hBEEF);
    rand_run(20, 5);

    // DDR mode
    rst_n = 0;
    settle();
    settle();
    rst_n = 1;
    cfg_odd = 0;
    drive_raw(1, 1, 32'hFFFF_1357, {1'b0, ^16'h1357}, 0);
    drive_raw(1, 0, 32'h0000_2468, {1'b1, ^16'h2468}, 0);
    settle();
    check(pair_valid && pair_i == 16'h1357 && pair_q == 16'h2468, "R3",
          "ddr pair", int'(pair_i), 16'h1357);
    check(!pair_err_i && !pair_err_q, "R4", "upper lane ignored",
          int'({pair_err_i, pair_err_q}), 0);
    drive(1, 0, 32'h0000_5555, 0, 0, 0);
    settle();
    check(!pair_valid, "R6", "orphan dropped", int'(pair_valid), 0);
    drive(1, 1, 32'h0000_1111, 0, 0, 0);
    drive(1, 1, 32'h0000_2222, 1, 1, 0);
    drive(1, 0, 32'h0000_3333, 0, 0, 0);
    settle();
    check(pair_valid && pair_i == 16'h2222, "R6", "second I kept", int'(pair_i), 16'h2222);
    rand_run(120, 5);
    cfg_odd = 1;
    rand_run(60, 3);

    // Back to wide through reset
    cfg_ddr = 0;
    rst_n = 0;
    settle();
    settle();
    rst_n = 1;
    rand_run(40, 4);
    settle();
    settle();
    finish_run();
  end

endmodule